// File: doc/BRIEF.md
# Serial Receiver with Parity Check

This block turns an asynchronous serial line into received words. A word has one start bit, eight or nine data bits sent least significant bit first, and one stop bit. The line is read on a 16x oversampling tick, and each bit is decided by majority vote over three samples taken around its middle. In nine-bit mode the ninth bit goes to a separate output. Parity can be checked on the most significant data bit, for even or odd parity. A parity error sets a flag, and the flag drives an interrupt only when its enable is set.

For multi-drop links the receiver can be put into a mute state. While muted it delivers nothing. It leaves the mute state in one of two ways, chosen by a mode input. In the first, the line stays idle for one full frame time. In the second, a word arrives whose most significant bit is 1.

Top module: `uart_par_rx`

## Requirements
- R1: In idle, a low line at a tick starts a frame (that tick is sample 0). The frame goes on only if the majority of samples 7, 8 and 9 is low. Otherwise the receiver returns to idle and produces no output.
- R2: Each data and stop bit is the majority of its samples 7, 8 and 9. One wrong sample within that window does not change the received value. Clock cycles without a tick have no effect.
- R3: With `cfg_nine`=0 the frame has 8 data bits, `rx_data` holds all of them and `rx_bit8` is 0. With `cfg_nine`=1 the frame has 9 data bits, `rx_data` holds bits 0 to 7 and `rx_bit8` holds bit 8.
- R4: With parity enabled, the XOR of all received data bits, including the MSB (bit 7 or bit 8), must be 0 when `cfg_par_odd`=0 and 1 when `cfg_par_odd`=1. A mismatch sets `par_err`. The parity bit stays in the data outputs. With parity disabled, `par_err` is 0.
- R5: `par_err` and `frm_err` are rewritten only when a word is delivered. Between deliveries they hold.
- R6: Parity enable, parity select and word length are captured when a start bit is accepted. A change during a frame applies from the next frame.
- R7: `irq` equals `par_err` AND `cfg_irq_en`, and follows the live value of the enable.
- R8: `rx_ready` is a pulse one clock long, given once per delivered word, in the clock after the stop bit's middle tick.
- R9: A low stop bit sets `frm_err`. A high stop bit clears it.
- R10: A `mute_set` pulse enters the mute state, shown on `rx_muted`. While muted, a word that does not wake the receiver gives no `rx_ready`, and all data and flag outputs hold.
- R11: With `cfg_wake_addr`=1, a word whose MSB is 1 ends the mute state and is delivered. A word whose MSB is 0 is dropped.
- R12: With `cfg_wake_addr`=0, the mute state ends once the line has been idle and high for (`cfg_nine` ? 11 : 10) x 16 ticks counted after `mute_set`. In this mode an MSB of 1 does not wake the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1: nine data bits |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_odd | input | 1 | 0 even, 1 odd parity |
| cfg_irq_en | input | 1 | Parity interrupt enable |
| cfg_wake_addr | input | 1 | 0 idle-line wake, 1 address-mark wake |
| mute_set | input | 1 | Pulse: enter mute state |
| rx_data | output | 8 | Received data bits 0 to 7 |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_ready | output | 1 | Word delivered pulse |
| par_err | output | 1 | Parity error of last delivered word |
| frm_err | output | 1 | Stop bit error of last delivered word |
| irq | output | 1 | Parity error interrupt |
| rx_muted | output | 1 | Mute state |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and an eight-bit data path. These values make both frame lengths short enough to sweep every byte value in eight-bit mode with parity on, changing the parity sense and the interrupt enable from word to word. Nine-bit words are swept with a stride of 5. At this size the whole idle-line wake window of 160 or 176 ticks can also be driven, with checks both before and after it ends. Ticks are sometimes spaced out over several clocks, and single samples are flipped, to exercise the enable and the majority vote.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rxp_bitclk.sv
module rxp_bitclk #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic restart,
  output logic mid,
  output logic maj
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2 + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    hist_q, hist_d;

  always_comb begin
    cnt_d  = cnt_q;
    hist_d = hist_q;
    if (tick) begin
      hist_d = {hist_q[0], rxd};
      if (restart)                    cnt_d = CW'(1);
      else if (cnt_q == CW'(OVS - 1)) cnt_d = '0;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hist_q <= 2'b11;
    end else begin
      cnt_q  <= cnt_d;
      hist_q <= hist_d;
    end
  end

  assign mid = tick && !restart && (cnt_q == CW'(MID));
  assign maj = (hist_q[1] & hist_q[0]) | (hist_q[1] & rxd) | (hist_q[0] & rxd);

  AST_RESTART_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> tick); // R1
endmodule

// File: rtl/rxp_frame.sv
module rxp_frame
  import rxp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          mid,
  input  logic          maj,
  input  logic          cfg_nine,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  output logic          restart,
  output logic          line_idle,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit8,
  output logic          msb,
  output logic          par_bad,
  output logic          stop_bad
);
  localparam int unsigned SW  = DW + 1;
  localparam int unsigned IXW = $clog2(DW + 1);

  rx_state_e      st_q, st_d;
  logic [IXW-1:0] idx_q, idx_d, last;
  logic [SW-1:0]  sr_q, sr_d;
  logic           nine_q, nine_d, pe_q, pe_d, po_q, po_d;
  logic           par_x;

  assign restart   = (st_q == ST_IDLE) && tick && !rxd;
  assign line_idle = (st_q == ST_IDLE);
  assign last      = nine_q ? IXW'(DW) : IXW'(DW - 1);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sr_d   = sr_q;
    nine_d = nine_q;
    pe_d   = pe_q;
    po_d   = po_q;
    case (st_q)
      ST_IDLE:  if (restart) st_d = ST_START;
      ST_START: if (mid) begin
        if (!maj) begin
          st_d   = ST_DATA;
          idx_d  = '0;
          nine_d = cfg_nine;
          pe_d   = cfg_par_en;
          po_d   = cfg_par_odd;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_DATA:  if (mid) begin
        sr_d = {maj, sr_q[SW-1:1]};
        if (idx_q == last) st_d = ST_STOP;
        else               idx_d = idx_q + 1'b1;
      end
      ST_STOP:  if (mid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sr_q   <= '0;
      nine_q <= 1'b0;
      pe_q   <= 1'b0;
      po_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
      nine_q <= nine_d;
      pe_q   <= pe_d;
      po_q   <= po_d;
    end
  end

  assign done     = (st_q == ST_STOP) && mid;
  assign stop_bad = !maj;
  assign data     = nine_q ? sr_q[DW-1:0] : sr_q[SW-1:1];
  assign bit8     = nine_q & sr_q[SW-1];
  assign msb      = sr_q[SW-1];
  assign par_x    = nine_q ? ^sr_q : ^sr_q[SW-1:1];
  assign par_bad  = pe_q & (par_x ^ po_q);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |=> ($stable(pe_q) && $stable(po_q) && $stable(nine_q))); // R6
  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_START) && mid && maj) |=> (st_q == ST_IDLE)); // R1
endmodule

// File: rtl/rxp_wake.sv
module rxp_wake #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic line_idle,
  input  logic cfg_nine,
  input  logic cfg_wake_addr,
  input  logic mute_set,
  input  logic done,
  input  logic msb,
  output logic muted,
  output logic deliver
);
  localparam int unsigned LIM8 = (DW + 2) * OVS;
  localparam int unsigned LIM9 = (DW + 3) * OVS;
  localparam int unsigned IW   = $clog2(LIM9 + 1);

  logic [IW-1:0] idle_q, idle_d, lim;
  logic          muted_q, muted_d, full, addr_wake;

  assign lim       = cfg_nine ? IW'(LIM9) : IW'(LIM8);
  assign full      = line_idle && rxd && tick && !mute_set && (idle_q == lim - 1'b1);
  assign addr_wake = done && msb && cfg_wake_addr;

  always_comb begin
    idle_d = idle_q;
    if (mute_set || !line_idle || !rxd)  idle_d = '0;
    else if (tick && (idle_q != lim))    idle_d = idle_q + 1'b1;
  end

  always_comb begin
    muted_d = muted_q;
    if (mute_set)                                       muted_d = 1'b1;
    else if (muted_q && (cfg_wake_addr ? addr_wake : full)) muted_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      muted_q <= 1'b0;
    end else begin
      idle_q  <= idle_d;
      muted_q <= muted_d;
    end
  end

  assign muted   = muted_q;
  assign deliver = done && (!muted_q || addr_wake);

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted_q) |-> ($past(cfg_wake_addr) ? $past(done && msb) : $past(line_idle && rxd))); // R11
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          cfg_nine,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_irq_en,
  input  logic          cfg_wake_addr,
  input  logic          mute_set,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_ready,
  output logic          par_err,
  output logic          frm_err,
  output logic          irq,
  output logic          rx_muted
);
  logic          restart, mid, maj, line_idle, done, bit8, msb, par_bad, stop_bad, deliver;
  logic [DW-1:0] data;

  logic [DW-1:0] data_q, data_d;
  logic          b8_q, b8_d, rdy_q, pe_q, pe_d, fe_q, fe_d;

  rxp_bitclk #(.OVS(OVS)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .restart(restart), .mid(mid), .maj(maj)
  );

  rxp_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mid(mid), .maj(maj),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .restart(restart), .line_idle(line_idle), .done(done), .data(data),
    .bit8(bit8), .msb(msb), .par_bad(par_bad), .stop_bad(stop_bad)
  );

  rxp_wake #(.OVS(OVS), .DW(DW)) u_wake (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .line_idle(line_idle),
    .cfg_nine(cfg_nine), .cfg_wake_addr(cfg_wake_addr), .mute_set(mute_set),
    .done(done), .msb(msb), .muted(rx_muted), .deliver(deliver)
  );

  always_comb begin
    data_d = data_q;
    b8_d   = b8_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    if (deliver) begin
      data_d = data;
      b8_d   = bit8;
      pe_d   = par_bad;
      fe_d   = stop_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      b8_q   <= 1'b0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      b8_q   <= b8_d;
      rdy_q  <= deliver;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_bit8  = b8_q;
  assign rx_ready = rdy_q;
  assign par_err  = pe_q;
  assign frm_err  = fe_q;
  assign irq      = pe_q & cfg_irq_en;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pe_q) || !$stable(fe_q) || !$stable(data_q)) |-> rdy_q); // R5
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !$past(mute_set)) |-> !rx_muted); // R10
endmodule

// File: tb/uart_par_rx_tb.sv
module uart_par_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n, tick, rxd, cfg_nine, cfg_par_en, cfg_par_odd, cfg_irq_en, cfg_wake_addr, mute_set;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_ready, par_err, frm_err, irq, rx_muted;

  int errs = 0, checks = 0, nrdy = 0, tdiv = 1;
  bit done_flag = 0;

  always #4 clk = ~clk;

  uart_par_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .cfg_nine(cfg_nine),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_irq_en(cfg_irq_en),
    .cfg_wake_addr(cfg_wake_addr), .mute_set(mute_set), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_ready(rx_ready), .par_err(par_err), .frm_err(frm_err),
    .irq(irq), .rx_muted(rx_muted)
  );

  always @(negedge clk) if (rx_ready) nrdy++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tk(input logic v);
    rxd  = v;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int k = 1; k < tdiv; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int t = 0; t < n; t++) tk(1'b1);
  endtask

  task automatic send(input int nb, input logic [8:0] v, input logic stopv, input int gl);
    for (int t = 0; t < 16; t++) tk(1'b0);
    for (int b = 0; b < nb; b++)
      for (int t = 0; t < 16; t++) tk((t == 8 && b == gl) ? ~v[b] : v[b]);
    for (int t = 0; t < 16; t++) tk(stopv);
    idle(12);
  endtask

  function automatic int exp_pe(input int nb, input logic [8:0] v, input logic pe, input logic odd);
    logic x;
    x = (nb == 9) ? ^v : ^v[7:0];
    return int'(pe & (x ^ odd));
  endfunction

  task automatic pulse_mute();
    mute_set = 1'b1;
    @(negedge clk);
    mute_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 0; tick = 0; rxd = 1; cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0;
    cfg_irq_en = 0; cfg_wake_addr = 0; mute_set = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset rx_ready", rx_ready, 0);
    check("reset par_err R5", par_err, 0);
    check("reset frm_err R9", frm_err, 0);
    check("reset irq R7", irq, 0);
    check("reset rx_muted R10", rx_muted, 0);
    check("reset rx_data", rx_data, 0);

    // R3 R4 R7 R8: all bytes, 8-bit mode, parity on, sense and irq enable varied
    cfg_par_en = 1;
    for (int i = 0; i < 256; i++) begin
      logic [8:0] v;
      v = 9'(i);
      cfg_par_odd = v[0] ^ v[4];
      cfg_irq_en  = v[1];
      n0 = nrdy;
      send(8, v, 1'b1, -1);
      check("R8 one ready per word", nrdy - n0, 1);
      check("R3 data 8-bit", rx_data, i);
      check("R3 bit8 zero", rx_bit8, 0);
      check("R4 parity", par_err, exp_pe(8, v, 1'b1, cfg_par_odd));
      check("R7 irq", irq, exp_pe(8, v, 1'b1, cfg_par_odd) & int'(cfg_irq_en));
    end

    // R3 R4: 9-bit sweep
    cfg_nine = 1;
    for (int i = 0; i < 512; i += 5) begin
      logic [8:0] v;
      v = 9'(i);
      cfg_par_en  = v[1];
      cfg_par_odd = v[3];
      send(9, v, 1'b1, -1);
      check("R3 data 9-bit", rx_data, i & 255);
      check("R3 bit8", rx_bit8, int'(v[8]));
      check("R4 parity 9-bit", par_err, exp_pe(9, v, cfg_par_en, cfg_par_odd));
    end

    // R2: sample glitches and sparse ticks
    cfg_nine = 0; cfg_par_en = 0; tdiv = 3;
    send(8, 9'h0A5, 1'b1, 3);
    check("R2 glitch bit3", rx_data, 'hA5);
    send(8, 9'h03C, 1'b1, 0);
    check("R2 glitch bit0", rx_data, 'h3C);
    send(8, 9'h0C3, 1'b1, 7);
    check("R2 glitch bit7", rx_data, 'hC3);
    tdiv = 1;

    // R1: false start
    n0 = nrdy;
    for (int t = 0; t < 5; t++) tk(1'b0);
    idle(30);
    check("R1 false start no ready", nrdy - n0, 0);
    check("R1 false start data held", rx_data, 'hC3);
    send(8, 9'h05A, 1'b1, -1);
    check("R1 frame after false start", rx_data, 'h5A);

    // R6: parity settings captured at start
    cfg_par_en = 1; cfg_par_odd = 0;
    fork
      send(8, 9'h001, 1'b1, -1);
      begin repeat (40) @(negedge clk); cfg_par_odd = 1; end
    join
    check("R6 old select used", par_err, 1);
    send(8, 9'h001, 1'b1, -1);
    check("R6 new select next word", par_err, 0);
    cfg_par_en = 0; cfg_par_odd = 0;
    fork
      send(8, 9'h007, 1'b1, -1);
      begin repeat (40) @(negedge clk); cfg_par_en = 1; end
    join
    check("R6 enable late no effect", par_err, 0);
    send(8, 9'h007, 1'b1, -1);
    check("R6 enable next word", par_err, 1);

    // R7: live irq enable
    cfg_irq_en = 0;
    @(negedge clk);
    check("R7 irq off", irq, 0);
    cfg_irq_en = 1;
    @(negedge clk);
    check("R7 irq on", irq, 1);
    cfg_par_en = 0;

    // R9 R5: stop bit errors and holding
    send(8, 9'h011, 1'b0, -1);
    check("R9 low stop", frm_err, 1);
    idle(40);
    check("R5 frm_err held", frm_err, 1);
    send(8, 9'h012, 1'b1, -1);
    check("R9 good stop clears", frm_err, 0);

    // R10 R11: address-mark wake, 8-bit
    cfg_wake_addr = 1;
    pulse_mute();
    check("R10 muted", rx_muted, 1);
    n0 = nrdy;
    cfg_par_en = 1;
    send(8, 9'h031, 1'b1, -1);
    check("R10 dropped no ready", nrdy - n0, 0);
    check("R10 data held", rx_data, 'h12);
    check("R10 par_err held", par_err, 0);
    check("R11 still muted", rx_muted, 1);
    cfg_par_en = 0;
    send(8, 9'h085, 1'b1, -1);
    check("R11 wake word delivered", nrdy - n0, 1);
    check("R11 wake data", rx_data, 'h85);
    check("R11 unmuted", rx_muted, 0);

    // R11: 9-bit, MSB is bit 8
    cfg_nine = 1;
    pulse_mute();
    n0 = nrdy;
    send(9, 9'h0FF, 1'b1, -1);
    check("R11 9-bit msb0 dropped", nrdy - n0, 0);
    send(9, 9'h123, 1'b1, -1);
    check("R11 9-bit msb1 wakes", rx_muted, 0);
    check("R11 9-bit bit8", rx_bit8, 1);
    check("R11 9-bit data", rx_data, 'h23);

    // R12: idle-line wake, 8-bit
    cfg_nine = 0; cfg_wake_addr = 0;
    pulse_mute();
    n0 = nrdy;
    send(8, 9'h055, 1'b1, -1);
    send(8, 9'h086, 1'b1, -1);
    check("R12 words dropped", nrdy - n0, 0);
    check("R12 msb1 no wake", rx_muted, 1);
    idle(100);
    check("R12 short idle still muted", rx_muted, 1);
    idle(80);
    check("R12 full idle wakes", rx_muted, 0);
    send(8, 9'h077, 1'b1, -1);
    check("R12 delivered after wake", nrdy - n0, 1);
    check("R12 data", rx_data, 'h77);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule